// File: doc/BRIEF.md
# Two-Cycle Flash Command Decoder

This block is the command front end of a block-erased parallel flash, written as synthesizable logic around a small internal byte array. A host issues bus write cycles, each carrying an address and a data byte. The block decodes them as one-cycle commands (return to array reads, identifier reads, status reads, clear errors) or as multi-cycle setup and confirm sequences (block erase, single-byte program, buffered write). A status register reports a ready flag and latched error flags. A busy timer holds the ready flag low for a fixed number of clocks after each erase or program operation, in place of real programming times.

The read data port is combinational from the address. What it returns depends on the current read mode: array contents, identifier bytes, the status byte, or an extended status byte that reports whether the write buffer is free. The erase block and the write buffer sizes are scaled down through parameters. The low-voltage and locked conditions come from input pins and make an operation fail instead of running.

The controller has six states. S_IDLE accepts commands, but only while ready is high. S_ERASE_CONF waits for the erase confirm byte. S_PROG_ARM waits for the byte to program. S_WB_COUNT takes the buffered-write byte count. S_WB_DATA collects the buffer bytes. S_WB_CONF waits for the buffered-write confirm byte. The transitions are:

- S_IDLE to S_ERASE_CONF on 0x20.
- S_IDLE to S_PROG_ARM on 0x40.
- S_IDLE to S_WB_COUNT on 0xE8.
- S_WB_COUNT to S_WB_DATA on the next write.
- S_WB_DATA to S_WB_CONF after the last counted byte.
- S_ERASE_CONF, S_PROG_ARM and S_WB_CONF to S_IDLE on their next write, whether that write is accepted or rejected.

Top module: `flash_cui`

## Requirements
- R1: After reset the read mode is array, every array byte reads 0xFF, and the status byte reads 0x80.
- R2: Writing 0xFF while ready selects array mode, and reads then return the stored byte at the address.
- R3: Writing 0x90 while ready selects identifier mode. Reads return 0x89 when addr[1:0] is 0, 0x18 when it is 1, and 0x00 otherwise.
- R4: Writing 0x70 while ready selects status mode. The status byte layout is:
  - bit 7: ready
  - bit 6: erase suspended, always 0
  - bit 5: erase error
  - bit 4: program error
  - bit 3: low voltage
  - bit 2: program suspended, always 0
  - bit 1: locked
  - bit 0: 0
- R5: Writing 0x50 while ready clears status bits 5, 4, 3 and 1 and leaves the read mode unchanged.
- R6: 0x20 followed by 0xD0 erases a block: every byte whose address bits above bit BLK_BITS-1 match those of the confirm address becomes 0xFF. All other blocks keep their contents.
- R7: 0x20 followed by any byte other than 0xD0 sets status bits 5 and 4 (mask 0x30), changes no array byte, and does not clear ready.
- R8: 0x40 followed by a write of data D to address A sets array[A] to old AND D.
- R9: A buffered write runs as follows:
  - 0xE8 starts it, and reads return 0x80 until the confirm byte.
  - The next write gives the count N-1 in bits [4:0].
  - The next N writes store bytes into a 32-entry buffer indexed by addr[4:0]; a later byte at the same index replaces the earlier one. The first of these writes fixes the 32-byte-aligned base.
  - A confirm of 0xD0 ANDs every stored entry into the array at base plus index.
  - Any other confirm byte sets bits 5 and 4 and programs nothing.
- R10: A started erase or program holds ready low for exactly BUSY_CYCLES clocks. Writes made while ready is low are ignored.
- R11: If low_volt or locked is high at the confirming write, the operation changes no array byte and leaves ready high.
  - A failed erase sets bit 5; a failed single or buffered program sets bit 4.
  - In both cases bit 3 is set if low_volt is high and bit 1 if locked is high.
- R12: After 0x20, 0x40, or the confirming write of any erase or program sequence, reads return the status byte at any address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Bus address for writes and reads |
| wdata | input | 8 | Bus write data (command or program byte) |
| low_volt | input | 1 | Supply too low; operations fail |
| locked | input | 1 | Target locked; operations fail |
| rdata | output | 8 | Read data selected by the read mode |

## Verification
Mode changes, error flags and array updates all take effect at the clock edge that accepts the write. The combinational read port therefore shows them at the next falling edge, and the bench samples there with the write strobe low. The ready flag stays low from that accepting edge until BUSY_CYCLES further edges have passed. The bench reads status after BUSY_CYCLES-1 falling edges and expects ready low, then reads again one edge later and expects ready high. Expected array contents, buffer contents and flags come from a bench model that is updated by the same rules as the requirements.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ERASE_CONF,
        S_PROG_ARM,
        S_WB_COUNT,
        S_WB_DATA,
        S_WB_CONF
    } cui_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_IDENT,
        RM_STATUS,
        RM_XSTATUS
    } read_mode_t;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
        logic low_volt;
        logic locked;
    } err_flags_t;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_PROG    = 8'h40;
    localparam logic [7:0] CMD_WBUF    = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;

    localparam logic [7:0] ID_MFR = 8'h89;
    localparam logic [7:0] ID_DEV = 8'h18;

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign ready = (cnt == '0);
endmodule

// File: rtl/flash_wbuf.sv
module flash_wbuf #(
    parameter int BUF_BITS = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr,
    input  logic [BUF_BITS-1:0]        idx,
    input  logic [7:0]                 wdata,
    output logic [(1<<BUF_BITS)*8-1:0] buf_data,
    output logic [(1<<BUF_BITS)-1:0]   buf_valid
);
    localparam int ENTRIES = 1 << BUF_BITS;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                buf_data[g*8 +: 8] <= 8'h00;
                buf_valid[g]       <= 1'b0;
            end else if (clear) begin
                buf_valid[g] <= 1'b0;
            end else if (wr && idx == BUF_BITS'(g)) begin
                buf_data[g*8 +: 8] <= wdata;
                buf_valid[g]       <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int ADDR_W   = 8,
    parameter int BLK_BITS = 6,
    parameter int BUF_BITS = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       erase,
    input  logic                       prog,
    input  logic                       commit,
    input  logic [ADDR_W-1:0]          op_addr,
    input  logic [7:0]                 prog_data,
    input  logic [(1<<BUF_BITS)*8-1:0] buf_data,
    input  logic [(1<<BUF_BITS)-1:0]   buf_valid,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BUFN  = 1 << BUF_BITS;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (erase && (ADDR_W'(i) >> BLK_BITS) == (op_addr >> BLK_BITS)) begin
                    mem[i] <= 8'hFF;
                end else if (prog && ADDR_W'(i) == op_addr) begin
                    mem[i] <= mem[i] & prog_data;
                end else if (commit && (ADDR_W'(i) >> BUF_BITS) == (op_addr >> BUF_BITS)
                             && buf_valid[i % BUFN]) begin
                    mem[i] <= mem[i] & buf_data[(i % BUFN)*8 +: 8];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_cui_fsm.sv
module flash_cui_fsm
    import flash_cui_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BUF_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    input  logic                low_volt,
    input  logic                locked,
    input  logic                ready,
    output cui_state_t          state,
    output read_mode_t          rmode,
    output logic [7:0]          status,
    output logic                start,
    output logic                erase,
    output logic                prog,
    output logic                commit,
    output logic [ADDR_W-1:0]   op_addr,
    output logic                wb_clear,
    output logic                wb_wr
);
    localparam int BASE_W = ADDR_W - BUF_BITS;

    cui_state_t          nxt_state;
    read_mode_t          nxt_rmode;
    err_flags_t          err, nxt_err;
    logic [BUF_BITS-1:0] remain, nxt_remain;
    logic [BASE_W-1:0]   base, nxt_base;
    logic                first, nxt_first;
    logic                fault;

    assign fault  = low_volt | locked;
    assign status = {ready, 1'b0, err.erase_err, err.prog_err,
                     err.low_volt, 1'b0, err.locked, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            rmode  <= RM_ARRAY;
            err    <= '0;
            remain <= '0;
            base   <= '0;
            first  <= 1'b0;
        end else begin
            state  <= nxt_state;
            rmode  <= nxt_rmode;
            err    <= nxt_err;
            remain <= nxt_remain;
            base   <= nxt_base;
            first  <= nxt_first;
        end
    end

    always_comb begin
        nxt_state  = state;
        nxt_rmode  = rmode;
        nxt_err    = err;
        nxt_remain = remain;
        nxt_base   = base;
        nxt_first  = first;
        start      = 1'b0;
        erase      = 1'b0;
        prog       = 1'b0;
        commit     = 1'b0;
        wb_clear   = 1'b0;
        wb_wr      = 1'b0;
        op_addr    = addr;
        unique case (state)
            S_IDLE: begin
                if (we && ready) begin
                    case (wdata)
                        CMD_ARRAY:  nxt_rmode = RM_ARRAY;
                        CMD_IDENT:  nxt_rmode = RM_IDENT;
                        CMD_STATUS: nxt_rmode = RM_STATUS;
                        CMD_CLEAR:  nxt_err   = '0;
                        CMD_ERASE: begin
                            nxt_state = S_ERASE_CONF;
                            nxt_rmode = RM_STATUS;
                        end
                        CMD_PROG: begin
                            nxt_state = S_PROG_ARM;
                            nxt_rmode = RM_STATUS;
                        end
                        CMD_WBUF: begin
                            nxt_state = S_WB_COUNT;
                            nxt_rmode = RM_XSTATUS;
                            wb_clear  = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            S_ERASE_CONF: begin
                if (we) begin
                    nxt_state = S_IDLE;
                    if (wdata != CMD_CONFIRM) begin
                        nxt_err.erase_err = 1'b1;
                        nxt_err.prog_err  = 1'b1;
                    end else if (fault) begin
                        nxt_err.erase_err = 1'b1;
                        nxt_err.low_volt  = err.low_volt | low_volt;
                        nxt_err.locked    = err.locked | locked;
                    end else begin
                        erase = 1'b1;
                        start = 1'b1;
                    end
                end
            end
            S_PROG_ARM: begin
                if (we) begin
                    nxt_state = S_IDLE;
                    if (fault) begin
                        nxt_err.prog_err = 1'b1;
                        nxt_err.low_volt = err.low_volt | low_volt;
                        nxt_err.locked   = err.locked | locked;
                    end else begin
                        prog  = 1'b1;
                        start = 1'b1;
                    end
                end
            end
            S_WB_COUNT: begin
                if (we) begin
                    nxt_remain = wdata[BUF_BITS-1:0];
                    nxt_first  = 1'b1;
                    nxt_state  = S_WB_DATA;
                end
            end
            S_WB_DATA: begin
                if (we) begin
                    wb_wr = 1'b1;
                    if (first) begin
                        nxt_base  = addr[ADDR_W-1:BUF_BITS];
                        nxt_first = 1'b0;
                    end
                    if (remain == '0) nxt_state = S_WB_CONF;
                    else nxt_remain = remain - 1'b1;
                end
            end
            S_WB_CONF: begin
                op_addr = {base, {BUF_BITS{1'b0}}};
                if (we) begin
                    nxt_state = S_IDLE;
                    nxt_rmode = RM_STATUS;
                    if (wdata != CMD_CONFIRM) begin
                        nxt_err.erase_err = 1'b1;
                        nxt_err.prog_err  = 1'b1;
                    end else if (fault) begin
                        nxt_err.prog_err = 1'b1;
                        nxt_err.low_volt = err.low_volt | low_volt;
                        nxt_err.locked   = err.locked | locked;
                    end else begin
                        commit = 1'b1;
                        start  = 1'b1;
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/flash_cui.sv
module flash_cui
    import flash_cui_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BLK_BITS    = 6,
    parameter int BUF_BITS    = 5,
    parameter int BUSY_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              low_volt,
    input  logic              locked,
    output logic [7:0]        rdata
);
    localparam int BUFN = 1 << BUF_BITS;

    cui_state_t          fsm_state;
    read_mode_t          rd_mode;
    logic [7:0]          status_byte;
    logic                ready, busy_start;
    logic                do_erase, do_prog, do_commit, wb_clear, wb_wr;
    logic [ADDR_W-1:0]   op_addr;
    logic [BUFN*8-1:0]   buf_data;
    logic [BUFN-1:0]     buf_valid;
    logic [7:0]          array_byte;

    flash_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(busy_start), .ready(ready)
    );

    flash_cui_fsm #(.ADDR_W(ADDR_W), .BUF_BITS(BUF_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .low_volt(low_volt), .locked(locked), .ready(ready),
        .state(fsm_state), .rmode(rd_mode), .status(status_byte),
        .start(busy_start), .erase(do_erase), .prog(do_prog),
        .commit(do_commit), .op_addr(op_addr),
        .wb_clear(wb_clear), .wb_wr(wb_wr)
    );

    flash_wbuf #(.BUF_BITS(BUF_BITS)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .clear(wb_clear), .wr(wb_wr),
        .idx(addr[BUF_BITS-1:0]), .wdata(wdata),
        .buf_data(buf_data), .buf_valid(buf_valid)
    );

    flash_array #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS), .BUF_BITS(BUF_BITS)) u_array (
        .clk(clk), .rst_n(rst_n), .erase(do_erase), .prog(do_prog),
        .commit(do_commit), .op_addr(op_addr), .prog_data(wdata),
        .buf_data(buf_data), .buf_valid(buf_valid),
        .rd_addr(addr), .rd_data(array_byte)
    );

    always_comb begin
        unique case (rd_mode)
            RM_ARRAY:   rdata = array_byte;
            RM_IDENT:   rdata = (addr[1:0] == 2'd0) ? ID_MFR :
                                (addr[1:0] == 2'd1) ? ID_DEV : 8'h00;
            RM_STATUS:  rdata = status_byte;
            RM_XSTATUS: rdata = 8'h80;
        endcase
    end
endmodule

// File: rtl/flash_cui_checker.sv
module flash_cui_checker
    import flash_cui_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input cui_state_t        state,
    input read_mode_t        rmode,
    input logic [7:0]        status,
    input logic              ready,
    input logic              start
);
    a_r7_seq_error: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERASE_CONF && we && wdata != CMD_CONFIRM) |=> (status[5:4] == 2'b11));

    a_r5_clear_errors: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && ready && we && wdata == CMD_CLEAR)
        |=> (status[5:3] == 3'b000 && status[1] == 1'b0));

    a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);

    a_r10_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(status[5:1]) && state == S_IDLE);

    a_r3_ident_mfr: assert property (@(posedge clk) disable iff (!rst_n)
        (rmode == RM_IDENT && addr[1:0] == 2'd0) |-> rdata == ID_MFR);

    a_r12_status_view: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERASE_CONF || state == S_PROG_ARM) |-> rdata == status);
endmodule

bind flash_cui flash_cui_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .state(fsm_state), .rmode(rd_mode),
    .status(status_byte), .ready(ready), .start(busy_start)
);

// File: tb/flash_cui_test.sv
module flash_cui_test;
    localparam int AW    = 8;
    localparam int BLK   = 6;
    localparam int BB    = 5;
    localparam int BUSY  = 20;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic          lv = 1'b0;
    logic          lk = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] mm [DEPTH];
    logic me, mp, mlv, mlk;

    flash_cui #(.ADDR_W(AW), .BLK_BITS(BLK), .BUF_BITS(BB), .BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .low_volt(lv), .locked(lk), .rdata(rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] st(input logic rdy);
        return {rdy, 1'b0, me, mp, mlv, 1'b0, mlk, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_done();
        logic [7:0] v;
        repeat (BUSY - 1) @(negedge clk);
        rd(8'h00, v); chk("R10 ready low at last busy cycle", v, st(1'b0));
        @(negedge clk);
        rd(8'h00, v); chk("R10 ready high after busy", v, st(1'b1));
    endtask

    task automatic clear_err();
        wr(8'h00, 8'h50);
        me = 0; mp = 0; mlv = 0; mlk = 0;
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d);
        logic [7:0] v;
        wr(a, 8'h40);
        rd(a ^ 8'h5A, v); chk("R12 status view after program setup", v, st(1'b1));
        wr(a, d);
        if (lv || lk) begin
            mp = 1; mlv = mlv | lv; mlk = mlk | lk;
            rd(a, v); chk("R11 program fault flags", v, st(1'b1));
        end else begin
            mm[a] = mm[a] & d;
            wait_done();
        end
    endtask

    task automatic do_erase(input logic [AW-1:0] a);
        logic [7:0] v;
        wr(a, 8'h20);
        rd(a, v); chk("R12 status view after erase setup", v, st(1'b1));
        wr(a, 8'hD0);
        if (lv || lk) begin
            me = 1; mlv = mlv | lv; mlk = mlk | lk;
            rd(a, v); chk("R11 erase fault flags", v, st(1'b1));
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if ((i >> BLK) == (int'(a) >> BLK)) mm[i] = 8'hFF;
            wait_done();
        end
    endtask

    task automatic do_wbuf(input logic [AW-1:0] base, input int n, input logic [7:0] conf);
        logic [7:0] v;
        logic [7:0] bd [32];
        logic       bv [32];
        for (int i = 0; i < 32; i++) begin bv[i] = 0; bd[i] = 0; end
        wr(base, 8'hE8);
        rd(base, v); chk("R9 extended status buffer free", v, 8'h80);
        wr(base, 8'(n - 1));
        for (int k = 0; k < n; k++) begin
            int off;
            logic [7:0] d;
            off = int'($urandom % 32);
            d = 8'($urandom);
            bd[off] = d; bv[off] = 1;
            wr((k == 0) ? (base | 8'(off)) : (8'($urandom) & 8'hE0) | 8'(off), d);
        end
        rd(base, v); chk("R9 extended status before confirm", v, 8'h80);
        wr(base, conf);
        if (conf != 8'hD0) begin
            me = 1; mp = 1;
            rd(base, v); chk("R9 bad buffered confirm", v, st(1'b1));
        end else if (lv || lk) begin
            mp = 1; mlv = mlv | lv; mlk = mlk | lk;
            rd(base, v); chk("R11 buffered program fault", v, st(1'b1));
        end else begin
            for (int i = 0; i < 32; i++)
                if (bv[i]) mm[int'(base) + i] = mm[int'(base) + i] & bd[i];
            wait_done();
        end
    endtask

    task automatic cmp_all(input string tag);
        logic [7:0] v;
        wr(8'h00, 8'hFF);
        for (int i = 0; i < DEPTH; i++) begin
            rd(8'(i), v); chk(tag, v, mm[i]);
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd2718));
        for (int i = 0; i < DEPTH; i++) mm[i] = 8'hFF;
        me = 0; mp = 0; mlv = 0; mlk = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h37, v); chk("R1 array erased after reset", v, 8'hFF);
        wr(8'h00, 8'h70);
        rd(8'h00, v); chk("R1 R4 status after reset", v, 8'h80);

        // R3 identifier
        wr(8'h00, 8'h90);
        rd(8'h00, v); chk("R3 manufacturer code", v, 8'h89);
        rd(8'h41, v); chk("R3 device code", v, 8'h18);
        rd(8'h02, v); chk("R3 other offset", v, 8'h00);

        // R8 program and AND rule, R2 array read
        do_prog(8'h05, 8'h3C);
        wr(8'h00, 8'hFF);
        rd(8'h05, v); chk("R2 R8 programmed byte", v, 8'h3C);
        do_prog(8'h05, 8'hF0);
        do_prog(8'h45, 8'h12);
        wr(8'h00, 8'hFF);
        rd(8'h05, v); chk("R8 program only clears bits", v, 8'h30);

        // R10 writes during busy are ignored
        wr(8'h10, 8'h40);
        wr(8'h10, 8'h0F);
        mm[8'h10] = 8'h0F;
        wr(8'h00, 8'hFF);
        rd(8'h10, v); chk("R10 write during busy ignored", v, st(1'b0));
        repeat (BUSY) @(negedge clk);
        rd(8'h10, v); chk("R10 mode kept status after busy", v, st(1'b1));

        // R7 sequence error, R5 clear keeps mode
        wr(8'h00, 8'h20);
        wr(8'h00, 8'h55);
        me = 1; mp = 1;
        rd(8'h00, v); chk("R7 sequence error flags", v, 8'hB0);
        clear_err();
        rd(8'h05, v); chk("R5 clear keeps status mode", v, 8'h80);
        cmp_all("R7 array unchanged by bad erase");

        // R6 erase block 0, block 1 intact
        do_erase(8'h21);
        cmp_all("R6 block erase");

        // R11 faults
        lv = 1;
        do_erase(8'h45);
        rd(8'h00, v); chk("R11 erase low voltage status", v, 8'hA8);
        lv = 0;
        clear_err();
        lk = 1;
        do_prog(8'h45, 8'h00);
        rd(8'h00, v); chk("R11 program locked status", v, 8'h92);
        do_wbuf(8'h60, 4, 8'hD0);
        lk = 0;
        clear_err();
        cmp_all("R11 array unchanged by failed ops");

        // R9 buffered write and bad confirm
        do_wbuf(8'h60, 3, 8'hD0);
        do_wbuf(8'h80, 32, 8'hD0);
        do_wbuf(8'hA0, 2, 8'h77);
        clear_err();
        cmp_all("R9 buffered write contents");

        // random mix
        for (int it = 0; it < 60; it++) begin
            int op;
            op = int'($urandom % 4);
            lv = ($urandom % 10) == 0;
            lk = ($urandom % 10) == 0;
            clear_err();
            case (op)
                0, 1: do_prog(8'($urandom), 8'($urandom));
                2: do_erase(8'($urandom));
                default: do_wbuf(8'($urandom) & 8'hE0, 1 + int'($urandom % 32), 8'hD0);
            endcase
            lv = 0; lk = 0;
            wr(8'h00, 8'hFF);
            for (int k = 0; k < 4; k++) begin
                int a;
                a = int'($urandom % DEPTH);
                rd(8'(a), v); chk("R2 R6 R8 R9 random array read", v, mm[a]);
            end
        end
        cmp_all("R2 final array compare");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule